// File: doc/BRIEF.md
# ATA PIO Cycle Timing Generator

This block runs a single programmed-I/O cycle on a parallel ATA device bus. After a one-clock start request, it goes through four phases, each measured in system clock cycles. In the setup phase the address is stable before the strobe. In the strobe phase the read or write strobe is asserted. In the hold phase the bus data stays valid after the strobe. In the recovery phase the cycle pads out to its full length. When recovery ends, the block pulses done and returns to idle.

Each of the two attached devices has two 32-bit timing words. The command word times register cycles and the data word times data transfers. Every word holds four 8-bit phase counts, each stored as the number of clocks minus one. The block copies the selected word when the cycle is accepted. Each device also has an enable bit for ready-line wait states: when set, a low ready line at the end of the strobe holds the strobe asserted until the device releases it.

A host-side sequencer uses the block one cycle at a time. It drives the cycle attributes with the start pulse and waits for done.

Top module: `ata_pio_timer`

## Requirements
- R1: While rst_ni is low, and after it is released, dior_no and diow_no are high, data_oe_o, done_o and busy_o are low, and rdata_o is zero.
- R2: An accepted cycle spends T1+1 clocks in setup, T2+1 clocks in strobe (without wait states), T4+1 clocks in hold and TEOC+1 clocks in recovery. done_o is high for exactly the final recovery clock, and the block is idle on the next clock.
- R3: A timing word holds setup count T1 in bits [7:0], strobe count T2 in [15:8], hold count T4 in [23:16] and recovery count TEOC in [31:24]. Every field value, including zero, is legal.
- R4: Device d uses bits [32d+31:32d] of its word bus. A cycle with data_cycle_i=0 uses cmd_timing_i, and a cycle with data_cycle_i=1 uses data_timing_i.
- R5: A read cycle (write_i=0) drives only dior_no low, and a write cycle drives only diow_no low, in both cases only during strobe.
- R6: In a write cycle, data_oe_o is high and wdata_o equals the accepted write data from the first setup clock through the last hold clock. In a read cycle data_oe_o stays low.
- R7: In a read cycle, rdata_o takes the value of rdata_dev_i sampled on the clock edge that ends the strobe. It holds that value until the next read capture.
- R8: When iordy_en_i[dev] is set and iordy_i is low on the last strobe clock, the strobe continues until the first clock on which iordy_i is high. When the bit is clear, iordy_i has no effect.
- R9: Timing words and enable bits are sampled when the cycle is accepted. Changes made during a cycle do not alter that cycle.
- R10: start_i is ignored while busy_o is high.
- R11: addr_o and dev_o keep the values accepted at start for the whole cycle, even if addr_i or dev_i change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request one cycle; accepted when idle |
| write_i | input | 1 | 1 = write cycle, 0 = read cycle |
| data_cycle_i | input | 1 | 1 = data transfer timing, 0 = register timing |
| dev_i | input | 1 | Target device |
| addr_i | input | 3 | Device register address |
| wdata_i | input | 16 | Write data |
| cmd_timing_i | input | 64 | Register-cycle timing words, one per device |
| data_timing_i | input | 64 | Data-cycle timing words, one per device |
| iordy_en_i | input | 2 | Per-device ready wait enable |
| iordy_i | input | 1 | Device ready line |
| rdata_dev_i | input | 16 | Data bus from device |
| dior_no | output | 1 | Read strobe, active low |
| diow_no | output | 1 | Write strobe, active low |
| addr_o | output | 3 | Latched device address |
| dev_o | output | 1 | Latched device select |
| data_oe_o | output | 1 | Write data output enable |
| wdata_o | output | 16 | Write data to bus |
| rdata_o | output | 16 | Captured read data |
| busy_o | output | 1 | Cycle in progress |
| done_o | output | 1 | Last clock of cycle |

## Verification
A table of eight cycles covers every combination of device and timing class, both directions, all-zero fields and asymmetric field values. Because the two devices and the two classes are programmed with distinct words, a wrong field order or a wrong word selection shows up as a wrong phase length.

Ready-line patterns include a wait of several clocks with the enable set, ready already high with the enable set, and a long low ready with the enable clear. Together these separate a working stretch from one that never happens and from one that ignores the enable.

The device data bus changes value on every clock. The captured value therefore identifies the exact edge on which the capture happened.

Directed cycles change the timing words, the address and the data in the middle of a cycle and also raise start again while busy. A reset is applied during a strobe.

// File: rtl/ata_pio_pkg.sv
package ata_pio_pkg;
  localparam int FIELD_W = 8;
  localparam int WORD_W  = 4 * FIELD_W;

  typedef enum logic [2:0] {
    PH_IDLE    = 3'd0,
    PH_SETUP   = 3'd1,
    PH_STROBE  = 3'd2,
    PH_HOLD    = 3'd3,
    PH_RECOVER = 3'd4
  } phase_e;

  // packed MSB first: recovery[31:24], hold[23:16], strobe[15:8], setup[7:0]
  typedef struct packed {
    logic [FIELD_W-1:0] recov;
    logic [FIELD_W-1:0] hold;
    logic [FIELD_W-1:0] pulse;
    logic [FIELD_W-1:0] setup;
  } pio_timing_t;
endpackage

// File: rtl/ata_pio_timing_sel.sv
module ata_pio_timing_sel
  import ata_pio_pkg::*;
#(
  parameter int NUM_DEV = 2,
  localparam int DEV_W  = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
  input  logic [NUM_DEV*WORD_W-1:0] cmd_words_i,
  input  logic [NUM_DEV*WORD_W-1:0] data_words_i,
  input  logic [DEV_W-1:0]          dev_i,
  input  logic                      data_cycle_i,
  output pio_timing_t               timing_o
);
  pio_timing_t cmd_set  [NUM_DEV];
  pio_timing_t data_set [NUM_DEV];

  for (genvar d = 0; d < NUM_DEV; d++) begin : g_unpack
    assign cmd_set[d]  = pio_timing_t'(cmd_words_i[d*WORD_W +: WORD_W]);
    assign data_set[d] = pio_timing_t'(data_words_i[d*WORD_W +: WORD_W]);
  end

  always_comb begin
    timing_o = data_cycle_i ? data_set[0] : cmd_set[0];
    for (int d = 1; d < NUM_DEV; d++) begin
      if (dev_i == DEV_W'(d)) timing_o = data_cycle_i ? data_set[d] : cmd_set[d];
    end
  end
endmodule

// File: rtl/ata_pio_phase_fsm.sv
module ata_pio_phase_fsm
  import ata_pio_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  pio_timing_t timing_i,
  input  logic        wait_en_i,
  input  logic        iordy_i,
  output phase_e      phase_o,
  output logic        launch_o,
  output logic        strobe_end_o,
  output logic        done_o
);
  phase_e             phase_q;
  logic [FIELD_W-1:0] cnt_q;
  logic [FIELD_W-1:0] pulse_q, hold_q, recov_q;
  logic               wait_en_q;
  logic               last_clk, stall;

  assign last_clk     = (cnt_q == '0);
  assign stall        = wait_en_q && !iordy_i;
  assign launch_o     = (phase_q == PH_IDLE) && start_i;
  assign strobe_end_o = (phase_q == PH_STROBE) && last_clk && !stall;
  assign done_o       = (phase_q == PH_RECOVER) && last_clk;
  assign phase_o      = phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q   <= PH_IDLE;
      cnt_q     <= '0;
      pulse_q   <= '0;
      hold_q    <= '0;
      recov_q   <= '0;
      wait_en_q <= 1'b0;
    end else begin
      unique case (phase_q)
        PH_IDLE: if (start_i) begin
          phase_q   <= PH_SETUP;
          cnt_q     <= timing_i.setup;
          pulse_q   <= timing_i.pulse;
          hold_q    <= timing_i.hold;
          recov_q   <= timing_i.recov;
          wait_en_q <= wait_en_i;
        end
        PH_SETUP: if (last_clk) begin
          phase_q <= PH_STROBE;
          cnt_q   <= pulse_q;
        end else cnt_q <= cnt_q - 1'b1;
        PH_STROBE: if (strobe_end_o) begin
          phase_q <= PH_HOLD;
          cnt_q   <= hold_q;
        end else if (!last_clk) cnt_q <= cnt_q - 1'b1;
        PH_HOLD: if (last_clk) begin
          phase_q <= PH_RECOVER;
          cnt_q   <= recov_q;
        end else cnt_q <= cnt_q - 1'b1;
        PH_RECOVER: if (last_clk) phase_q <= PH_IDLE;
                    else cnt_q <= cnt_q - 1'b1;
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  // R8: ready low on the last strobe clock keeps the strobe
  assert_iordy_stretch_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_STROBE && last_clk && wait_en_q && !iordy_i) |=> phase_q == PH_STROBE);
  assert_done_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (phase_q == PH_IDLE && !done_o));
  // R10: setup is only entered from idle
  assert_no_restart_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q != PH_IDLE && phase_q != PH_SETUP) |=> phase_q != PH_SETUP);
endmodule

// File: rtl/ata_pio_datapath.sv
module ata_pio_datapath
  import ata_pio_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 3,
  parameter int DEV_W  = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              launch_i,
  input  logic              strobe_end_i,
  input  phase_e            phase_i,
  input  logic              write_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DEV_W-1:0]  dev_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] rdata_dev_i,
  output logic              dior_no,
  output logic              diow_no,
  output logic              data_oe_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DEV_W-1:0]  dev_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic              wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DEV_W-1:0]  dev_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic              in_strobe, drive_win;

  assign in_strobe = (phase_i == PH_STROBE);
  assign drive_win = (phase_i == PH_SETUP) || in_strobe || (phase_i == PH_HOLD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q    <= 1'b0;
      addr_q  <= '0;
      dev_q   <= '0;
      wdata_q <= '0;
    end else if (launch_i) begin
      wr_q    <= write_i;
      addr_q  <= addr_i;
      dev_q   <= dev_i;
      wdata_q <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     rdata_q <= '0;
    else if (strobe_end_i && !wr_q)  rdata_q <= rdata_dev_i;
  end

  assign dior_no   = !(in_strobe && !wr_q);
  assign diow_no   = !(in_strobe && wr_q);
  assign data_oe_o = drive_win && wr_q;
  assign wdata_o   = data_oe_o ? wdata_q : '0;
  assign addr_o    = addr_q;
  assign dev_o     = dev_q;
  assign rdata_o   = rdata_q;

  assert_one_strobe_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!dior_no && !diow_no));
  assert_oe_not_read_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> dior_no);
  assert_read_capture_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dior_no) |-> rdata_o == $past(rdata_dev_i));
  assert_addr_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_i != PH_IDLE) |=> $stable(addr_o) && $stable(dev_o));
endmodule

// File: rtl/ata_pio_timer.sv
module ata_pio_timer
  import ata_pio_pkg::*;
#(
  parameter int NUM_DEV = 2,
  parameter int DATA_W  = 16,
  parameter int ADDR_W  = 3,
  localparam int DEV_W  = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      start_i,
  input  logic                      write_i,
  input  logic                      data_cycle_i,
  input  logic [DEV_W-1:0]          dev_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [DATA_W-1:0]         wdata_i,
  input  logic [NUM_DEV*WORD_W-1:0] cmd_timing_i,
  input  logic [NUM_DEV*WORD_W-1:0] data_timing_i,
  input  logic [NUM_DEV-1:0]        iordy_en_i,
  input  logic                      iordy_i,
  input  logic [DATA_W-1:0]         rdata_dev_i,
  output logic                      dior_no,
  output logic                      diow_no,
  output logic [ADDR_W-1:0]         addr_o,
  output logic [DEV_W-1:0]          dev_o,
  output logic                      data_oe_o,
  output logic [DATA_W-1:0]         wdata_o,
  output logic [DATA_W-1:0]         rdata_o,
  output logic                      busy_o,
  output logic                      done_o
);
  pio_timing_t timing_sel;
  phase_e      phase;
  logic        launch, strobe_end;

  ata_pio_timing_sel #(.NUM_DEV(NUM_DEV)) u_sel (
    .cmd_words_i  (cmd_timing_i),
    .data_words_i (data_timing_i),
    .dev_i        (dev_i),
    .data_cycle_i (data_cycle_i),
    .timing_o     (timing_sel)
  );

  ata_pio_phase_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .timing_i     (timing_sel),
    .wait_en_i    (iordy_en_i[dev_i]),
    .iordy_i      (iordy_i),
    .phase_o      (phase),
    .launch_o     (launch),
    .strobe_end_o (strobe_end),
    .done_o       (done_o)
  );

  ata_pio_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .DEV_W(DEV_W)) u_dp (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .launch_i     (launch),
    .strobe_end_i (strobe_end),
    .phase_i      (phase),
    .write_i      (write_i),
    .addr_i       (addr_i),
    .dev_i        (dev_i),
    .wdata_i      (wdata_i),
    .rdata_dev_i  (rdata_dev_i),
    .dior_no      (dior_no),
    .diow_no      (diow_no),
    .data_oe_o    (data_oe_o),
    .wdata_o      (wdata_o),
    .addr_o       (addr_o),
    .dev_o        (dev_o),
    .rdata_o      (rdata_o)
  );

  assign busy_o = (phase != PH_IDLE);

  assert_done_busy_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_o);
endmodule

// File: tb/ata_pio_timer_tb.sv
module ata_pio_timer_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0, write_i = 1'b0, data_cycle_i = 1'b0;
  logic [0:0]  dev_i = '0;
  logic [2:0]  addr_i = '0;
  logic [15:0] wdata_i = '0, rdata_dev_i = '0;
  logic [63:0] cmd_timing_i = '0, data_timing_i = '0;
  logic [1:0]  iordy_en_i = '0;
  logic        iordy_i = 1'b1;
  logic        dior_no, diow_no, data_oe_o, busy_o, done_o;
  logic [2:0]  addr_o;
  logic [0:0]  dev_o;
  logic [15:0] wdata_o, rdata_o;

  int total = 0, bad = 0;

  always #5 clk = ~clk;

  ata_pio_timer u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .write_i(write_i),
    .data_cycle_i(data_cycle_i), .dev_i(dev_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .cmd_timing_i(cmd_timing_i), .data_timing_i(data_timing_i),
    .iordy_en_i(iordy_en_i), .iordy_i(iordy_i), .rdata_dev_i(rdata_dev_i),
    .dior_no(dior_no), .diow_no(diow_no), .addr_o(addr_o), .dev_o(dev_o),
    .data_oe_o(data_oe_o), .wdata_o(wdata_o), .rdata_o(rdata_o),
    .busy_o(busy_o), .done_o(done_o)
  );

  // {dev, data_cycle, write, iordy_en, wait[3:0]} , {recov, hold, pulse, setup}
  localparam logic [39:0] VEC [8] = '{
    {8'h00, 32'h02010503}, {8'h60, 32'h00000000},
    {8'hA0, 32'h00020402}, {8'hC0, 32'h03000701},
    {8'h53, 32'h01010201}, {8'h90, 32'h00000100},
    {8'hE4, 32'h02020202}, {8'h32, 32'h01030004}
  };
  localparam logic [31:0] OTHER = 32'h0F0E0D0C;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_one(input int idx, input logic [7:0] ctl, input logic [31:0] word,
                         input bit midchg);
    logic d, dc, wr, ien;
    int wt, t1, t2, t4, te, ext;
    int k, setup_n, strobe_n, post_n, oe_n, wrong_n, wd_err, ad_err, done_n;
    logic [15:0] wd;
    logic [2:0]  ad;
    d = ctl[7]; dc = ctl[6]; wr = ctl[5]; ien = ctl[4]; wt = int'(ctl[3:0]);
    t1 = int'(word[7:0]); t2 = int'(word[15:8]); t4 = int'(word[23:16]); te = int'(word[31:24]);
    ext = ien ? wt : 0;
    wd = 16'h5A00 + 16'(idx); ad = 3'(idx + 3);
    @(negedge clk);
    cmd_timing_i  = {OTHER, OTHER};
    data_timing_i = {OTHER, OTHER};
    if (dc) data_timing_i[d*32 +: 32] = word;
    else    cmd_timing_i[d*32 +: 32]  = word;
    iordy_en_i[d] = ien; iordy_en_i[!d] = !ien;
    dev_i = d; data_cycle_i = dc; write_i = wr; addr_i = ad; wdata_i = wd;
    iordy_i = (wt == 0); start_i = 1'b1;
    setup_n = 0; strobe_n = 0; post_n = 0; oe_n = 0; wrong_n = 0;
    wd_err = 0; ad_err = 0; done_n = 0; k = 0;
    @(negedge clk);
    start_i = 1'b0;
    forever begin
      if (wr ? !dior_no : !diow_no) wrong_n++;
      if ((wr ? diow_no : dior_no) == 1'b0) strobe_n++;
      else if (strobe_n == 0) setup_n++;
      else post_n++;
      if (data_oe_o) begin oe_n++; if (wdata_o != wd) wd_err++; end
      if (addr_o != ad || dev_o != d) ad_err++;
      if (done_o) done_n++;
      rdata_dev_i = 16'hA000 + 16'(k);
      if (strobe_n >= t2 + 1 + wt || (strobe_n > 0 && (wr ? diow_no : dior_no))) iordy_i = 1'b1;
      if (midchg && k == 1) begin
        cmd_timing_i = '1; data_timing_i = '1; iordy_en_i = ~iordy_en_i;
        addr_i = ~ad; dev_i = !d; wdata_i = ~wd; start_i = 1'b1;
      end
      if (midchg && k == 2) start_i = 1'b0;
      if (done_o || k > 2000) break;
      k++;
      @(negedge clk);
    end
    chk(setup_n == t1 + 1, $sformatf("R2 R3 R4 setup len vec%0d", idx), setup_n, t1 + 1);
    chk(strobe_n == t2 + 1 + ext, $sformatf("R2 R3 R8 strobe len vec%0d", idx), strobe_n, t2 + 1 + ext);
    chk(post_n == t4 + te + 2, $sformatf("R2 R3 R9 hold+recovery vec%0d", idx), post_n, t4 + te + 2);
    chk(wrong_n == 0, $sformatf("R5 wrong strobe vec%0d", idx), wrong_n, 0);
    chk(oe_n == (wr ? t1 + t2 + t4 + 3 + ext : 0), $sformatf("R6 oe len vec%0d", idx),
        oe_n, wr ? t1 + t2 + t4 + 3 + ext : 0);
    chk(wd_err == 0, $sformatf("R6 write data vec%0d", idx), wd_err, 0);
    chk(ad_err == 0, $sformatf("R11 addr/dev hold vec%0d", idx), ad_err, 0);
    chk(done_n == 1, $sformatf("R2 done count vec%0d", idx), done_n, 1);
    if (!wr)
      chk(rdata_o == 16'hA000 + 16'(t1 + t2 + 1 + ext), $sformatf("R7 capture vec%0d", idx),
          int'(rdata_o), int'(16'hA000 + 16'(t1 + t2 + 1 + ext)));
    @(negedge clk);
    chk(!done_o && !busy_o, $sformatf("R2 R10 idle after done vec%0d", idx),
        int'({done_o, busy_o}), 0);
    iordy_i = 1'b1;
  endtask

  initial begin
    #2_000_000;
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] held;
    #1;
    chk(dior_no && diow_no && !data_oe_o && !busy_o && !done_o && rdata_o == 0,
        "R1 in reset", int'({dior_no, diow_no, data_oe_o, busy_o, done_o}), 5'b11000);
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(dior_no && diow_no && !data_oe_o && !busy_o && !done_o, "R1 after release",
        int'({dior_no, diow_no, data_oe_o, busy_o, done_o}), 5'b11000);

    for (int i = 0; i < 8; i++) run_one(i, VEC[i][39:32], VEC[i][31:0], 1'b0);

    // R9 R10 R11: mid-cycle changes and a second start while busy
    run_one(8, VEC[0][39:32], VEC[0][31:0], 1'b1);
    run_one(9, VEC[6][39:32], VEC[6][31:0], 1'b1);
    run_one(10, VEC[4][39:32], VEC[4][31:0], 1'b1);

    // R7: a write cycle leaves the captured read data unchanged
    held = rdata_o;
    run_one(11, VEC[2][39:32], VEC[2][31:0], 1'b0);
    chk(rdata_o == held, "R7 write keeps rdata", int'(rdata_o), int'(held));

    // R1: reset in the middle of a strobe
    @(negedge clk);
    cmd_timing_i = {32'h0, 32'h00000900}; dev_i = 1'b0; data_cycle_i = 1'b0;
    write_i = 1'b1; start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    @(negedge clk);
    chk(!diow_no, "R5 strobe before reset", int'(diow_no), 0);
    rst_ni = 1'b0; #1;
    chk(dior_no && diow_no && !data_oe_o && !busy_o && !done_o, "R1 reset mid-cycle",
        int'({dior_no, diow_no, data_oe_o, busy_o, done_o}), 5'b11000);
    @(negedge clk); rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy_o, "R1 idle after reset", int'(busy_o), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule